// File: doc/BRIEF.md
# RTC seconds counter with alarm

A real-time clock core that sits on a simple 32-bit register bus and runs from a slow clock of roughly 32 kHz. A programmable divider turns that clock into a once-per-second tick. The tick advances a free-running 32-bit seconds count. A 32-bit compare value can raise a sticky alarm flag, and each tick also raises a sticky per-second flag. Either flag can drive a single interrupt line through its own enable. A general-purpose 32-bit scratch word is also provided.

Software cannot change a register with a single store. It first stores a magic word into the unlock register. That grants exactly one register write. An accepted write does not land at once. The ready bit in the control register drops, and the new value takes effect only after a fixed number of clock cycles. This models the crossing into the slow domain, and software must poll ready before the next write. Software clears a flag by writing 0 to it. Writing 1 to a flag leaves it unchanged, so a read-modify-write of the control word never loses a pending event.

Top module: `rtc_core`

## Requirements
- R1: After reset the control word reads 0x80 (only ready set), the seconds, alarm, scratch and unlock words read 0, the divider word reads the PRESC_RST parameter, and irq is low.
- R2: Writing 0x0000A55A to the unlock register (offset 0x3C) makes its bit 31 read 1. Writing any other value there makes bit 31 read 0.
- R3: A write to control (0x00), seconds (0x04), alarm (0x08), divider (0x0C) or scratch (0x34) made while unlock bit 31 is 0 changes nothing.
- R4: The unlock is used up by the first accepted register write. Bit 31 reads 0 from the cycle after that write, and a further write is ignored.
- R5: An accepted write clears control bit 7 (ready) for SYNC_CYC cycles. The target keeps its old value until ready returns. A write that arrives while ready is 0 is ignored and does not use up the unlock.
- R6: With control bit 0 (run) set and divider value N, the seconds count rises by one every N+1 clock cycles. With run clear it holds.
- R7: The seconds count wraps from 0xFFFFFFFF to 0.
- R8: Each tick sets control bit 6 (second flag). While control bit 2 (alarm enable) is set and the seconds count equals the alarm word, control bit 4 (alarm flag) is set. With bit 2 clear, a match sets nothing.
- R9: A write that lands on control clears bit 6 or bit 4 only where the written bit is 0. A 1 leaves the flag as it was.
- R10: irq is high exactly when (bit 6 and bit 5, the second-interrupt enable) or (bit 4 and bit 3, the alarm-interrupt enable) hold.
- R11: After it lands, a write to the seconds or scratch register reads back the written 32-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock that drives all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Single-cycle write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register addressed for a read or a write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the core with PRESC_RST = 4 and SYNC_CYC = 2, leaving UNLOCK_EN at its default. A five-cycle second lets the bench observe several ticks, a change of divider, an alarm match and a counter wrap within a few hundred cycles. The two-cycle landing delay makes a write issued two strobes after an accepted one arrive on the last busy cycle. That is exactly the edge the rejection rule must cover.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   // register byte offsets (software decodes these)
   localparam logic [7:0] A_CTRL    = 8'h00;
   localparam logic [7:0] A_SECS    = 8'h04;
   localparam logic [7:0] A_ALARM   = 8'h08;
   localparam logic [7:0] A_PRESC   = 8'h0C;
   localparam logic [7:0] A_SCRATCH = 8'h34;
   localparam logic [7:0] A_UNLOCK  = 8'h3C;

   // control word bit positions
   localparam int B_READY = 7;
   localparam int B_TFLAG = 6;
   localparam int B_TIE   = 5;
   localparam int B_AFLAG = 4;
   localparam int B_AIE   = 3;
   localparam int B_AEN   = 2;
   localparam int B_RUN   = 0;
   localparam int B_OPEN  = 31;

   localparam logic [31:0] UNLOCK_WORD = 32'h0000_A55A;

   typedef struct packed {
      logic tflag;
      logic tie;
      logic aflag;
      logic aie;
      logic aen;
      logic run;
   } ctrl_t;

endpackage

// File: rtl/rtc_wr_gate.sv
module rtc_wr_gate
   import rtc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned SYNC_CYC  = 3,
   parameter bit          UNLOCK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic              ready,
   output logic              unlocked,
   output logic              accept,
   output logic              apply,
   output logic [ADDR_W-1:0] ap_addr,
   output logic [31:0]       ap_data
);

   localparam int unsigned CNT_W    = (SYNC_CYC > 1) ? $clog2(SYNC_CYC) : 1;
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SYNC_CYC - 1);

   logic             busy;
   logic [CNT_W-1:0] cnt;
   logic             hit_unlock;
   logic             hit_mapped;

   always_comb begin
      hit_unlock = (addr == ADDR_W'(A_UNLOCK));
      hit_mapped = (addr == ADDR_W'(A_CTRL))  || (addr == ADDR_W'(A_SECS))  ||
                   (addr == ADDR_W'(A_ALARM)) || (addr == ADDR_W'(A_PRESC)) ||
                   (addr == ADDR_W'(A_SCRATCH));
   end

   assign ready  = !busy;
   assign accept = wr_stb && hit_mapped && unlocked && !busy;
   assign apply  = busy && (cnt == '0);

   generate
      if (UNLOCK_EN) begin : g_lock
         logic open_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               open_q <= 1'b0;
            end else if (wr_stb && hit_unlock) begin
               open_q <= (wdata == UNLOCK_WORD);
            end else if (accept) begin
               open_q <= 1'b0;
            end
         end
         assign unlocked = open_q;
      end else begin : g_open
         assign unlocked = 1'b1;
      end
   endgenerate

   // hold the accepted write until it lands in the slow domain
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         cnt     <= '0;
         ap_addr <= '0;
         ap_data <= '0;
      end else if (accept) begin
         busy    <= 1'b1;
         cnt     <= CNT_LOAD;
         ap_addr <= addr;
         ap_data <= wdata;
      end else if (busy) begin
         if (cnt == '0) begin
            busy <= 1'b0;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int unsigned PRESC_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [PRESC_W-1:0] limit,
   output logic               tick
);

   logic [PRESC_W-1:0] div_q;

   // >= so that lowering the limit mid-count cannot skip a whole wrap
   assign tick = run && (div_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (!run || tick) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
   import rtc_pkg::*;
#(
   parameter int unsigned        ADDR_W     = 8,
   parameter int unsigned        PRESC_W    = 16,
   parameter logic [PRESC_W-1:0] PRESC_INIT = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               apply,
   input  logic [ADDR_W-1:0]  ap_addr,
   input  logic [31:0]        ap_data,
   input  logic               tick,
   output ctrl_t              ctrl_q,
   output logic [31:0]        secs_q,
   output logic [31:0]        alarm_q,
   output logic [PRESC_W-1:0] presc_q,
   output logic [31:0]        scratch_q,
   output logic               irq
);

   logic wr_ctrl, wr_secs, wr_alarm, wr_presc, wr_scratch;
   logic match;

   always_comb begin
      wr_ctrl    = apply && (ap_addr == ADDR_W'(A_CTRL));
      wr_secs    = apply && (ap_addr == ADDR_W'(A_SECS));
      wr_alarm   = apply && (ap_addr == ADDR_W'(A_ALARM));
      wr_presc   = apply && (ap_addr == ADDR_W'(A_PRESC));
      wr_scratch = apply && (ap_addr == ADDR_W'(A_SCRATCH));
      match      = ctrl_q.aen && (secs_q == alarm_q);
   end

   assign irq = (ctrl_q.tflag && ctrl_q.tie) || (ctrl_q.aflag && ctrl_q.aie);

   // control: enables take the written bits; flags set on events, clear on 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q.tie   <= ap_data[B_TIE];
         ctrl_q.aie   <= ap_data[B_AIE];
         ctrl_q.aen   <= ap_data[B_AEN];
         ctrl_q.run   <= ap_data[B_RUN];
         ctrl_q.tflag <= tick  || (ctrl_q.tflag && ap_data[B_TFLAG]);
         ctrl_q.aflag <= match || (ctrl_q.aflag && ap_data[B_AFLAG]);
      end else begin
         ctrl_q.tflag <= ctrl_q.tflag || tick;
         ctrl_q.aflag <= ctrl_q.aflag || match;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         secs_q <= '0;
      end else if (wr_secs) begin
         secs_q <= ap_data;
      end else if (tick) begin
         secs_q <= secs_q + 32'd1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm_q   <= '0;
         presc_q   <= PRESC_INIT;
         scratch_q <= '0;
      end else begin
         if (wr_alarm)   alarm_q   <= ap_data;
         if (wr_presc)   presc_q   <= ap_data[PRESC_W-1:0];
         if (wr_scratch) scratch_q <= ap_data;
      end
   end

endmodule

// File: rtl/rtc_core.sv
module rtc_core
   import rtc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned PRESC_W   = 16,
   parameter int unsigned PRESC_RST = 32767,
   parameter int unsigned SYNC_CYC  = 3,
   parameter bit          UNLOCK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              irq
);

   localparam logic [PRESC_W-1:0] PRESC_INIT = PRESC_W'(PRESC_RST);

   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("rtc_core: ADDR_W must reach offset 0x3C");
      end
      if (PRESC_W < 1 || PRESC_W > 32) begin : g_bad_presc
         $error("rtc_core: PRESC_W must lie in 1..32");
      end
      if (PRESC_W < 32 && 64'(PRESC_RST) >= (64'd1 << PRESC_W)) begin : g_bad_rst
         $error("rtc_core: PRESC_RST does not fit PRESC_W");
      end
      if (SYNC_CYC < 1) begin : g_bad_sync
         $error("rtc_core: SYNC_CYC must be at least 1");
      end
   endgenerate

   logic               ready, unlocked, accept, apply, tick;
   logic [ADDR_W-1:0]  ap_addr;
   logic [31:0]        ap_data;
   ctrl_t              ctrl_q;
   logic [31:0]        secs, alarm, scratch;
   logic [PRESC_W-1:0] presc;

   rtc_wr_gate #(
      .ADDR_W(ADDR_W), .SYNC_CYC(SYNC_CYC), .UNLOCK_EN(UNLOCK_EN)
   ) u_gate (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(bus_addr), .wdata(wdata),
      .ready(ready), .unlocked(unlocked), .accept(accept), .apply(apply),
      .ap_addr(ap_addr), .ap_data(ap_data)
   );

   rtc_prescaler #(.PRESC_W(PRESC_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .limit(presc), .tick(tick)
   );

   rtc_regs #(
      .ADDR_W(ADDR_W), .PRESC_W(PRESC_W), .PRESC_INIT(PRESC_INIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .apply(apply), .ap_addr(ap_addr), .ap_data(ap_data),
      .tick(tick), .ctrl_q(ctrl_q), .secs_q(secs), .alarm_q(alarm), .presc_q(presc),
      .scratch_q(scratch), .irq(irq)
   );

   always_comb begin
      rdata = '0;
      case (bus_addr)
         ADDR_W'(A_CTRL): begin
            rdata[B_READY] = ready;
            rdata[B_TFLAG] = ctrl_q.tflag;
            rdata[B_TIE]   = ctrl_q.tie;
            rdata[B_AFLAG] = ctrl_q.aflag;
            rdata[B_AIE]   = ctrl_q.aie;
            rdata[B_AEN]   = ctrl_q.aen;
            rdata[B_RUN]   = ctrl_q.run;
         end
         ADDR_W'(A_SECS):    rdata = secs;
         ADDR_W'(A_ALARM):   rdata = alarm;
         ADDR_W'(A_PRESC):   rdata = 32'(presc);
         ADDR_W'(A_SCRATCH): rdata = scratch;
         ADDR_W'(A_UNLOCK):  rdata[B_OPEN] = unlocked;
         default:            rdata = '0;
      endcase
   end

endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
   import rtc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter bit          UNLOCK_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_stb,
   input logic              unlocked,
   input logic              accept,
   input logic              ready,
   input logic              apply,
   input logic [ADDR_W-1:0] ap_addr,
   input logic [31:0]       ap_data,
   input logic              tick,
   input logic [31:0]       secs,
   input logic              tflag,
   input logic              aflag,
   input logic              aen
);

   logic secs_landing, ctrl_landing;
   assign secs_landing = apply && (ap_addr == ADDR_W'(A_SECS));
   assign ctrl_landing = apply && (ap_addr == ADDR_W'(A_CTRL));

   // R3
   locked_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !unlocked) |-> !accept);

   generate
      if (UNLOCK_EN) begin : g_once
         // R4
         unlock_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
            accept |=> !unlocked);
      end
   endgenerate

   // R5
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !ready);

   // R5
   busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !accept);

   // R6
   secs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !secs_landing) |=> $stable(secs));

   // R7
   secs_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !secs_landing && (secs == '1)) |=> (secs == '0));

   // R8
   alarm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(aflag) |-> $past(aen));

   // R9
   tflag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tflag) |-> $past(ctrl_landing && !ap_data[B_TFLAG]));

endmodule

bind rtc_core rtc_core_chk #(.ADDR_W(ADDR_W), .UNLOCK_EN(UNLOCK_EN)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .unlocked(unlocked), .accept(accept),
   .ready(ready), .apply(apply), .ap_addr(ap_addr), .ap_data(ap_data), .tick(tick),
   .secs(secs), .tflag(ctrl_q.tflag), .aflag(ctrl_q.aflag), .aen(ctrl_q.aen)
);

// File: tb/rtc_core_tb.sv
module rtc_core_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_stb = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   rtc_core #(.PRESC_RST(4), .SYNC_CYC(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .bus_addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   // {req[3:0], op[1:0], addr[7:0], data[31:0], expect[31:0]}
   // op 0 locked write, 1 read check, 2 idle data cycles, 3 unlock+write+wait
   localparam int NV = 19;
   localparam logic [77:0] VEC [0:NV-1] = '{
      {4'd11, 2'd3, 8'h34, 32'hDEADBEEF, 32'h0},         // R11 scratch write
      {4'd11, 2'd1, 8'h34, 32'h0,        32'hDEADBEEF},  // R11
      {4'd3,  2'd0, 8'h34, 32'h11111111, 32'h0},         // R3 locked write
      {4'd3,  2'd2, 8'h00, 32'd4,        32'h0},
      {4'd3,  2'd1, 8'h34, 32'h0,        32'hDEADBEEF},  // R3
      {4'd2,  2'd0, 8'h3C, 32'h0000A55A, 32'h0},
      {4'd2,  2'd1, 8'h3C, 32'h0,        32'h80000000},  // R2
      {4'd2,  2'd0, 8'h3C, 32'h00001234, 32'h0},
      {4'd2,  2'd1, 8'h3C, 32'h0,        32'h0},         // R2
      {4'd4,  2'd0, 8'h3C, 32'h0000A55A, 32'h0},
      {4'd4,  2'd0, 8'h08, 32'h00000005, 32'h0},
      {4'd4,  2'd1, 8'h3C, 32'h0,        32'h0},         // R4 consumed
      {4'd4,  2'd2, 8'h00, 32'd4,        32'h0},
      {4'd4,  2'd1, 8'h08, 32'h0,        32'h5},         // R4
      {4'd4,  2'd0, 8'h08, 32'h00000007, 32'h0},
      {4'd4,  2'd2, 8'h00, 32'd4,        32'h0},
      {4'd4,  2'd1, 8'h08, 32'h0,        32'h5},         // R4 second write ignored
      {4'd11, 2'd3, 8'h04, 32'h00000010, 32'h0},
      {4'd11, 2'd1, 8'h04, 32'h0,        32'h10}         // R11 seconds
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // all tasks start and end on a falling edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      wr_stb = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic wait_ready();
      logic [31:0] v;
      for (int i = 0; i < 50; i++) begin
         rd(8'h00, v);
         if (v[7]) break;
         @(negedge clk);
      end
   endtask

   task automatic uwr(input logic [7:0] a, input logic [31:0] d);
      wr(8'h3C, 32'h0000A55A);
      wr(a, d);
      wait_ready();
   endtask

   task automatic next_sec(output int cyc, output logic [31:0] nv);
      logic [31:0] old;
      rd(8'h04, old);
      cyc = 0;
      nv  = old;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         cyc++;
         rd(8'h04, nv);
         if (nv != old) break;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%h expected=%h", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, s0;
      logic [77:0] e;
      int c;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h00, v); chk("R1 ctrl", v, 32'h80);
      rd(8'h04, v); chk("R1 secs", v, 32'h0);
      rd(8'h08, v); chk("R1 alarm", v, 32'h0);
      rd(8'h0C, v); chk("R1 divider", v, 32'd4);
      rd(8'h34, v); chk("R1 scratch", v, 32'h0);
      rd(8'h3C, v); chk("R1 unlock", v, 32'h0);
      chk("R1 irq", 32'(irq), 32'h0);

      for (int i = 0; i < NV; i++) begin
         e = VEC[i];
         case (e[73:72])
            2'd0: wr(e[71:64], e[63:32]);
            2'd1: begin
               rd(e[71:64], v);
               chk($sformatf("R%0d vec%0d", e[77:74], i), v, e[31:0]);
            end
            2'd2: repeat (int'(e[63:32])) @(negedge clk);
            default: uwr(e[71:64], e[63:32]);
         endcase
      end

      // R5 landing delay and rejection while busy
      wr(8'h3C, 32'h0000A55A);
      wr(8'h34, 32'h0000000A);
      rd(8'h00, v); chk("R5 ready low after write", 32'(v[7]), 32'h0);
      rd(8'h34, v); chk("R5 old value held", v, 32'hDEADBEEF);
      wr(8'h3C, 32'h0000A55A);
      rd(8'h00, v); chk("R5 ready low second cycle", 32'(v[7]), 32'h0);
      wr(8'h34, 32'h0000000B);
      rd(8'h00, v); chk("R5 ready back", 32'(v[7]), 32'h1);
      rd(8'h34, v); chk("R5 landed, busy write ignored", v, 32'h0000000A);
      rd(8'h3C, v); chk("R5 unlock kept", v, 32'h80000000);
      wr(8'h3C, 32'h0);

      // R6 tick spacing
      uwr(8'h04, 32'h0);
      uwr(8'h00, 32'h01);
      next_sec(c, v);
      next_sec(c, v); chk("R6 period N=4", 32'(c), 32'd5);
      next_sec(c, v); chk("R6 period N=4 again", 32'(c), 32'd5);
      uwr(8'h0C, 32'd2);
      next_sec(c, v);
      next_sec(c, v); chk("R6 period N=2", 32'(c), 32'd3);
      uwr(8'h00, 32'h40);
      rd(8'h04, s0);
      repeat (20) @(negedge clk);
      rd(8'h04, v); chk("R6 held while stopped", v, s0);
      rd(8'h00, v); chk("R8 second flag set", v, 32'hC0);
      chk("R10 irq masked", 32'(irq), 32'h0);

      // R9 / R10 second flag
      uwr(8'h00, 32'h60);
      rd(8'h00, v); chk("R9 written 1 keeps flag", v, 32'hE0);
      chk("R10 irq from second flag", 32'(irq), 32'h1);
      uwr(8'h00, 32'h20);
      rd(8'h00, v); chk("R9 written 0 clears flag", v, 32'hA0);
      chk("R10 irq drops", 32'(irq), 32'h0);

      // R8 alarm
      uwr(8'h04, 32'h20);
      uwr(8'h08, 32'h22);
      uwr(8'h00, 32'h0D);
      for (int i = 0; i < 200; i++) begin
         rd(8'h04, v);
         if (v == 32'h22) break;
         @(negedge clk);
      end
      @(negedge clk);
      rd(8'h00, v); chk("R8 alarm flag", 32'(v[4]), 32'h1);
      chk("R10 irq from alarm", 32'(irq), 32'h1);
      uwr(8'h00, 32'h50);
      chk("R10 alarm masked", 32'(irq), 32'h0);
      rd(8'h00, v); chk("R9 alarm flag kept", 32'(v[4]), 32'h1);
      uwr(8'h00, 32'h00);
      rd(8'h00, v); chk("R9 both flags cleared", v, 32'h80);
      uwr(8'h04, 32'h22);
      repeat (3) @(negedge clk);
      rd(8'h00, v); chk("R8 no flag with alarm disabled", 32'(v[4]), 32'h0);

      // R7 wrap
      uwr(8'h04, 32'hFFFFFFFE);
      uwr(8'h00, 32'h01);
      next_sec(c, v); chk("R7 reaches all ones", v, 32'hFFFFFFFF);
      next_sec(c, v); chk("R7 wraps to zero", v, 32'h0);
      uwr(8'h00, 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule